// File: doc/BRIEF.md
# Bit-Serial Operand Adder

This block adds two unsigned operands of a configurable width by processing one bit position per clock cycle. A parallel load copies both operands into their own right-shifting registers and clears the result. A start pulse then begins a run. On each cycle of the run, the least significant bit of each operand register goes into a small carry-tracking state machine. The sum bit it produces is shifted into the most significant end of a result register. After every bit position has been consumed, the result register holds the sum modulo 2^WIDTH. A one-cycle done flag marks the point at which that value can be read.

A build-time parameter selects the form of the carry machine. The two-state form derives the sum bit combinationally from the operand bits and the stored carry. The four-state form registers the sum bit as part of its state, so that bit reaches the output one clock after its operand bits. The run controller gives the registered form one extra cycle and skips its first capture. Carry out of the top bit is discarded, and operands are treated as unsigned.

Top module: `bsa_top`

## Requirements
- R1: While reset is asserted and after it is released, `sum` is all zeros and `done` is 0.
- R2: A clock edge that samples `load`=1 copies `op_a` and `op_b` into the operand registers, clears `sum` to zero, clears the carry and aborts any run in progress, so that no `done` pulse follows from that run.
- R3: A clock edge that samples `start`=1 with `load`=0 while idle begins a run, and at the end of the run `sum` equals (`op_a` + `op_b`) mod 2^WIDTH of the last load.
- R4: With MOORE=0, `done` is 1 in the cycle after the WIDTH-th clock edge following the edge that accepted `start`, and `sum` is final in that cycle.
- R5: With MOORE=1, `done` is 1 in the cycle after the (WIDTH+1)-th clock edge following the edge that accepted `start`, and `sum` is final in that cycle.
- R6: `done` stays high for exactly one cycle per completed run.
- R7: A `start` pulse that arrives while a run is in progress is ignored. The running addition keeps its timing and its result.
- R8: While idle and without `load`, `sum` holds its value from cycle to cycle.
- R9: The carry ripples across all bit positions. A carry out of the top bit is dropped (for example, 0xFF + 0x01 gives 0x00 at WIDTH=8).
- R10: When `load` and `start` are both 1 on the same edge, load wins. No run starts, and `done` stays 0 until a later `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand, captured on load |
| op_b | input | WIDTH | Second operand, captured on load |
| load | input | 1 | Parallel load of the operands; clears the result and the carry |
| start | input | 1 | Begins a run when the block is idle |
| sum | output | WIDTH | Result register |
| done | output | 1 | One-cycle flag marking that the result is complete |

## Verification
The bench drives the two-state and the four-state variants side by side, so an off-by-one in the extra cycle of the registered form appears at once. That kind of error makes `done` fire a cycle early, or lets the first stale output bit into the result, which shifts every result bit by one place. The operand pairs are chosen so the carry has to ripple the full width or stop at the top bit. An FSM that lost the carry between states, or kept the overflow, would return a wrong sum. Directed cases cover a `start` during a run (a restart would move `done` later), `load` together with `start` (a spurious run would raise `done`) and `load` mid-run (a stale `done` or a non-zero `sum` would remain).

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // Two-state carry machine: the state is the carry into the current bit
  typedef enum logic {
    CY_CLR = 1'b0,
    CY_SET = 1'b1
  } cy2_e;

  // Four-state machine: MSB holds the carry, LSB holds the registered sum bit
  typedef enum logic [1:0] {
    CY0_S0 = 2'b00,
    CY0_S1 = 2'b01,
    CY1_S0 = 2'b10,
    CY1_S1 = 2'b11
  } cy4_e;
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             sh_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  // Load has priority over shift; a shift moves bits toward the LSB
  always_comb begin
    q_nxt = q;
    if (ld)
      q_nxt = ld_val;
    else if (sh_en)
      q_nxt = {ser_in, q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (ld || sh_en)
      q <= q_nxt;
  end
endmodule

// File: rtl/bsa_carry_fsm.sv
module bsa_carry_fsm #(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry
);
  import bsa_pkg::*;

  generate
    if (MOORE) begin : g_moore
      cy4_e st, st_nxt;
      logic c_nxt, s_nxt;

      always_comb begin
        s_nxt  = a_bit ^ b_bit ^ st[1];
        c_nxt  = (a_bit & b_bit) | (st[1] & (a_bit ^ b_bit));
        st_nxt = st;
        if (clr)
          st_nxt = CY0_S0;
        else if (step)
          st_nxt = cy4_e'({c_nxt, s_nxt});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          st <= CY0_S0;
        else if (clr || step)
          st <= st_nxt;
      end

      assign sum_bit = st[0];
      assign carry   = st[1];
    end else begin : g_mealy
      cy2_e st, st_nxt;

      always_comb begin
        st_nxt = st;
        if (clr)
          st_nxt = CY_CLR;
        else if (step) begin
          case (st)
            CY_CLR: if (a_bit && b_bit)   st_nxt = CY_SET;
            CY_SET: if (!a_bit && !b_bit) st_nxt = CY_CLR;
            default: st_nxt = CY_CLR;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          st <= CY_CLR;
        else if (clr || step)
          st <= st_nxt;
      end

      assign sum_bit = a_bit ^ b_bit ^ st;
      assign carry   = st;
    end
  endgenerate
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic start,
  output logic busy,
  output logic shift_op,
  output logic shift_res,
  output logic done
);
  localparam int CYC = WIDTH + (MOORE ? 1 : 0);
  localparam int CW  = $clog2(CYC + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          busy_nxt, done_nxt;

  always_comb begin
    cnt_nxt  = cnt;
    busy_nxt = busy;
    done_nxt = 1'b0;
    if (load) begin
      cnt_nxt  = '0;
      busy_nxt = 1'b0;
    end else if (busy) begin
      cnt_nxt = cnt - CW'(1);
      if (cnt == CW'(1)) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end
    end else if (start) begin
      cnt_nxt  = CW'(CYC);
      busy_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      busy <= busy_nxt;
      done <= done_nxt;
    end
  end

  assign shift_op = busy;

  generate
    if (MOORE) begin : g_skip_first
      // The first output of the registered form is stale; capture from cycle two on
      assign shift_res = busy && (cnt != CW'(CYC));
    end else begin : g_every
      assign shift_res = busy;
    end
  endgenerate
endmodule

// File: rtl/bsa_top.sv
module bsa_top #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             load,
  input  logic             start,
  output logic [WIDTH-1:0] sum,
  output logic             done
);
  logic [WIDTH-1:0] a_q, b_q;
  logic             busy, shift_op, shift_res;
  logic             sum_bit, carry;
  logic             a_lsb, b_lsb;

  bsa_seq #(.WIDTH(WIDTH), .MOORE(MOORE)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start),
    .busy(busy), .shift_op(shift_op), .shift_res(shift_res), .done(done)
  );

  bsa_shreg #(.WIDTH(WIDTH)) opa_i (
    .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(op_a),
    .sh_en(shift_op), .ser_in(1'b0), .q(a_q)
  );

  bsa_shreg #(.WIDTH(WIDTH)) opb_i (
    .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(op_b),
    .sh_en(shift_op), .ser_in(1'b0), .q(b_q)
  );

  assign a_lsb = a_q[0];
  assign b_lsb = b_q[0];

  bsa_carry_fsm #(.MOORE(MOORE)) fsm_i (
    .clk(clk), .rst_n(rst_n), .clr(load), .step(shift_op),
    .a_bit(a_lsb), .b_bit(b_lsb), .sum_bit(sum_bit), .carry(carry)
  );

  bsa_shreg #(.WIDTH(WIDTH)) res_i (
    .clk(clk), .rst_n(rst_n), .ld(load), .ld_val({WIDTH{1'b0}}),
    .sh_en(shift_res), .ser_in(sum_bit), .q(sum)
  );
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             step,
  input logic             carry,
  input logic             a_lsb,
  input logic             b_lsb,
  input logic [WIDTH-1:0] sum
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_load_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sum == '0 && !done && !busy && !carry));

  assert_load_beats_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && start) |=> !busy);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(sum));

  assert_start_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !load) |=> busy);

  assert_run_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !start) |=> (busy || done));

  assert_carry_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !carry && !(a_lsb && b_lsb)) |=> !carry);

  assert_carry_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && carry && (a_lsb || b_lsb)) |=> carry);
endmodule

bind bsa_top bsa_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .start(start), .busy(busy),
  .done(done), .step(shift_op), .carry(carry), .a_lsb(a_lsb),
  .b_lsb(b_lsb), .sum(sum)
);

// File: tb/bsa_top_tb_top.sv
module bsa_top_tb_top;
  localparam int W = 8;

  logic         clk, rst_n, load, start;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] sum_me, sum_mo;
  logic         done_me, done_mo;

  int n_chk, n_bad;
  bit finished;

  bsa_top #(.WIDTH(W), .MOORE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .load(load),
    .start(start), .sum(sum_me), .done(done_me)
  );

  bsa_top #(.WIDTH(W), .MOORE(1'b1)) dut_moore_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .load(load),
    .start(start), .sum(sum_mo), .done(done_mo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {a, b, expected sum}
  localparam logic [23:0] VEC [10] = '{
    24'h00_00_00, 24'h01_01_02, 24'hFF_01_00, 24'h55_AA_FF, 24'h80_80_00,
    24'h7F_01_80, 24'hC3_3C_FF, 24'h9A_67_01, 24'hFF_FF_FE, 24'h12_34_46
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  // Starts a run and checks both forms at their own completion cycle
  task automatic run(input logic [W-1:0] exp);
    start = 1'b1;
    tick();
    start = 1'b0;
    repeat (W) tick();
    chk(done_me === 1'b1, "R4 mealy done", done_me, 1);
    chk(sum_me === exp, "R3 mealy sum", sum_me, exp);
    chk(done_mo === 1'b0, "R5 moore not yet done", done_mo, 0);
    tick();
    chk(done_mo === 1'b1, "R5 moore done", done_mo, 1);
    chk(sum_mo === exp, "R3 moore sum", sum_mo, exp);
    chk(done_me === 1'b0, "R6 mealy done pulse", done_me, 0);
    tick();
    chk(done_mo === 1'b0, "R6 moore done pulse", done_mo, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; load = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) tick();
    // R1: reset state
    chk(sum_me === '0 && sum_mo === '0, "R1 sum in reset", {sum_me, sum_mo}, 0);
    chk(!done_me && !done_mo, "R1 done in reset", {done_me, done_mo}, 0);
    rst_n = 1'b1;
    tick();
    chk(sum_me === '0 && !done_me, "R1 after release", sum_me, 0);

    // R3/R9: vector table walk
    for (int i = 0; i < 10; i++) begin
      do_load(VEC[i][23:16], VEC[i][15:8]);
      chk(sum_me === '0 && sum_mo === '0, "R2 load clears sum", sum_me, 0);
      run(VEC[i][7:0]);
    end

    // R8: idle hold
    repeat (5) tick();
    chk(sum_me === 8'h46 && sum_mo === 8'h46, "R8 idle hold", sum_me, 8'h46);

    // R7: start during a run ignored
    do_load(8'h0F, 8'h01);
    start = 1'b1; tick(); start = 1'b0;
    repeat (3) tick();
    start = 1'b1; tick(); start = 1'b0;
    repeat (W - 4) tick();
    chk(done_me === 1'b1, "R7 mealy done timing kept", done_me, 1);
    chk(sum_me === 8'h10, "R7 mealy sum", sum_me, 8'h10);
    tick();
    chk(done_mo === 1'b1 && sum_mo === 8'h10, "R7 moore result", sum_mo, 8'h10);
    repeat (W + 2) begin
      tick();
      chk(!done_me && !done_mo, "R7 no second run", {done_me, done_mo}, 0);
    end

    // R10: load and start together
    op_a = 8'h03; op_b = 8'h04; load = 1'b1; start = 1'b1;
    tick();
    load = 1'b0; start = 1'b0;
    repeat (W + 2) begin
      tick();
      chk(!done_me && !done_mo, "R10 no run from load+start", {done_me, done_mo}, 0);
    end
    chk(sum_me === '0 && sum_mo === '0, "R10 sum still clear", sum_me, 0);
    run(8'h07);

    // R2: load mid-run aborts
    do_load(8'h11, 8'h22);
    start = 1'b1; tick(); start = 1'b0;
    repeat (4) tick();
    do_load(8'h00, 8'h00);
    chk(sum_me === '0 && sum_mo === '0, "R2 abort clears sum", sum_me, 0);
    repeat (W + 2) begin
      tick();
      chk(!done_me && !done_mo, "R2 aborted run no done", {done_me, done_mo}, 0);
    end
    run(8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule